// File: doc/BRIEF.md
# In-order commit reorder buffer

The block tracks instructions that have been dispatched but not yet made architecturally visible. A slot is claimed for every dispatched instruction in program order, and the slot's index serves as the tag the execution side later uses to report completion. Results and exception flags arrive out of order and are parked in the slot. Nothing reaches the architectural register file at that point.

A single commit stage examines only the oldest slot. When that slot is finished, it either commits or traps. A commit writes the register file, bumps the retired-instruction counter and advances the head. A trap throws away the slot and everything younger. Exceptions, debug single-step, fences and instruction counting are all resolved at this one point, so the visible state always matches a sequential run of the program.

A small read port exposes the architectural register file. It lets the surrounding logic, or a test, observe exactly what has been committed.

Top module: `inorder_commit_buf`

## Requirements
- R1: Dispatch claims the slot whose tag is shown on `disp_tag`, handing out tags in increasing order modulo DEPTH. `disp_ready` is low while DEPTH slots are occupied or while a trap is being taken. `buf_full` and `buf_empty` report the slot count.
- R2: A writeback stores its data and flags in the tagged slot only. The architectural register file is unchanged until that slot commits.
- R3: Commit happens only from the oldest slot. A finished slot that is younger than an unfinished oldest slot waits.
- R4: A committing slot that has a destination writes its data to the register file at the same edge that raises `retire_valid` with its tag for one cycle. The new value is readable on `arf_data` from the cycle after that edge.
- R5: `retired_count` rises by exactly one per commit. It never changes on dispatch or writeback.
- R6: When the oldest finished slot has a flag bit set that `flag_mask` does not mask, the block raises `trap_valid` with `trap_step`=0, the slot's PC on `trap_pc` and the unmasked flags on `trap_flags`. No register is written and no count is added. Flags that are fully masked are ignored and the slot commits normally.
- R7: Any trap empties the buffer in one edge. After a trap with `trap_step`=0, the next dispatch receives the faulting slot's tag.
- R8: With `step_en` high, every commit also raises `trap_valid` with `trap_step`=1 and the committed slot's PC, and all younger slots are discarded. A fault on the same slot takes priority and gives `trap_step`=0.
- R9: A fence slot needs no writeback and writes no register. It holds the head until `sb_empty` is high, then commits and is counted.
- R10: A writeback whose tag names a slot that is not occupied has no effect. A later dispatch into that slot still waits for its own writeback.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| disp_valid | input | 1 | Dispatch request |
| disp_fence | input | 1 | Dispatched entry is a fence |
| disp_wr | input | 1 | Dispatched entry writes a register |
| disp_dst | input | $clog2(NREGS) | Destination register index |
| disp_pc | input | PC_W | Program counter of the dispatched entry |
| disp_ready | output | 1 | Dispatch accepted this cycle |
| disp_tag | output | $clog2(DEPTH) | Tag given to the dispatched entry |
| wb_valid | input | 1 | Writeback strobe |
| wb_tag | input | $clog2(DEPTH) | Tag being completed |
| wb_data | input | DATA_W | Result value |
| wb_flags | input | XF_W | Exception flags from execution |
| flag_mask | input | XF_W | A set bit masks the matching flag |
| step_en | input | 1 | Single-step debug enable |
| sb_empty | input | 1 | Store buffer drained |
| arf_addr | input | $clog2(NREGS) | Register file read index |
| arf_data | output | DATA_W | Register file read data |
| retire_valid | output | 1 | An entry committed at the last edge |
| retire_tag | output | $clog2(DEPTH) | Tag of that entry |
| trap_valid | output | 1 | A trap was taken at the last edge |
| trap_step | output | 1 | 1 = single-step trap, 0 = exception trap |
| trap_pc | output | PC_W | PC of the trapping entry |
| trap_flags | output | XF_W | Unmasked flags (zero for a step trap) |
| retired_count | output | CNT_W | Committed-instruction count |
| occupancy | output | $clog2(DEPTH)+1 | Occupied slots |
| buf_full | output | 1 | All slots occupied |
| buf_empty | output | 1 | No slot occupied |

## Verification
`disp_ready` and `disp_tag` are combinational from the current state and the oldest slot, so they are checked in the same cycle the inputs are driven, just after the inputs settle. A writeback takes one edge to mark its slot finished. Commit is decided in the next cycle, and its effects (`retire_valid`, trap outputs, `retired_count`, occupancy and the register read) appear after a second edge. The bench drives inputs at the falling edge, predicts every result from the requirements for the edge that follows, and compares at the next falling edge. It therefore samples each result exactly one edge after the cycle that caused it.

// File: rtl/icb_pkg.sv
package icb_pkg;
   typedef enum logic {
      TRAP_FAULT = 1'b0,
      TRAP_STEP  = 1'b1
   } trap_kind_e;
endpackage

// File: rtl/icb_slots.sv
module icb_slots #(
   parameter int DEPTH  = 16,
   parameter int DATA_W = 32,
   parameter int PC_W   = 32,
   parameter int XF_W   = 4,
   parameter int RW     = 3
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     alloc,
   input  logic                     a_fence,
   input  logic                     a_wr,
   input  logic [RW-1:0]            a_dst,
   input  logic [PC_W-1:0]          a_pc,
   input  logic                     wb_valid,
   input  logic [$clog2(DEPTH)-1:0] wb_tag,
   input  logic [DATA_W-1:0]        wb_data,
   input  logic [XF_W-1:0]          wb_flags,
   input  logic                     pop,
   input  logic                     flush,
   output logic                     h_valid,
   output logic                     h_done,
   output logic                     h_fence,
   output logic                     h_wr,
   output logic [RW-1:0]            h_dst,
   output logic [DATA_W-1:0]        h_data,
   output logic [XF_W-1:0]          h_flags,
   output logic [PC_W-1:0]          h_pc,
   output logic [$clog2(DEPTH)-1:0] h_tag,
   output logic [$clog2(DEPTH)-1:0] tail_tag,
   output logic [$clog2(DEPTH):0]   count,
   output logic                     full,
   output logic                     empty
);
   localparam int TW = $clog2(DEPTH);

   logic [TW:0]       head_q, tail_q, head_nxt, tail_nxt;
   logic [TW-1:0]     head_ix, tail_ix;
   logic [DEPTH-1:0]  vld_v, done_v, fence_v, wr_v;
   logic [RW-1:0]     dst_a  [DEPTH];
   logic [DATA_W-1:0] data_a [DEPTH];
   logic [XF_W-1:0]   flg_a  [DEPTH];
   logic [PC_W-1:0]   pc_a   [DEPTH];

   assign head_ix = head_q[TW-1:0];
   assign tail_ix = tail_q[TW-1:0];

   // pointer update: a trap drops every slot from the new head onward
   assign head_nxt = head_q + {{TW{1'b0}}, pop};
   assign tail_nxt = flush ? head_nxt : (tail_q + {{TW{1'b0}}, alloc});

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         head_q <= '0;
         tail_q <= '0;
      end else begin
         head_q <= head_nxt;
         tail_q <= tail_nxt;
      end
   end

   generate
      for (genvar g = 0; g < DEPTH; g++) begin : g_slot
         logic              vld_q, done_q, fence_q, wr_q;
         logic [RW-1:0]     dst_q;
         logic [DATA_W-1:0] data_q;
         logic [XF_W-1:0]   flg_q;
         logic [PC_W-1:0]   pc_q;
         logic              hit_a, hit_w, hit_p;

         assign hit_a = alloc && (tail_ix == TW'(g));
         assign hit_w = wb_valid && (wb_tag == TW'(g)) && vld_q && !flush;
         assign hit_p = pop && (head_ix == TW'(g));

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               vld_q  <= 1'b0;
               done_q <= 1'b0;
            end else if (flush) begin
               vld_q  <= 1'b0;
               done_q <= 1'b0;
            end else if (hit_a) begin
               vld_q  <= 1'b1;
               done_q <= a_fence;
            end else begin
               if (hit_p) vld_q  <= 1'b0;
               if (hit_w) done_q <= 1'b1;
            end
         end

         always_ff @(posedge clk) begin
            if (hit_a) begin
               fence_q <= a_fence;
               wr_q    <= a_wr;
               dst_q   <= a_dst;
               pc_q    <= a_pc;
               data_q  <= '0;
               flg_q   <= '0;
            end else if (hit_w) begin
               data_q  <= wb_data;
               flg_q   <= wb_flags;
            end
         end

         assign vld_v[g]   = vld_q;
         assign done_v[g]  = done_q;
         assign fence_v[g] = fence_q;
         assign wr_v[g]    = wr_q;
         assign dst_a[g]   = dst_q;
         assign data_a[g]  = data_q;
         assign flg_a[g]   = flg_q;
         assign pc_a[g]    = pc_q;
      end
   endgenerate

   assign h_valid  = vld_v[head_ix];
   assign h_done   = done_v[head_ix];
   assign h_fence  = fence_v[head_ix];
   assign h_wr     = wr_v[head_ix];
   assign h_dst    = dst_a[head_ix];
   assign h_data   = data_a[head_ix];
   assign h_flags  = flg_a[head_ix];
   assign h_pc     = pc_a[head_ix];
   assign h_tag    = head_ix;
   assign tail_tag = tail_ix;

   assign count = tail_q - head_q;
   assign full  = (count == (TW+1)'(DEPTH));
   assign empty = (count == '0);

   // R1
   no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      alloc |-> !full);

   // R7
   flush_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
      flush |=> (empty && (vld_v == '0)));

   // R1
   count_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      count <= (TW+1)'(DEPTH));
endmodule

// File: rtl/icb_arch_rf.sv
module icb_arch_rf #(
   parameter int NREGS      = 8,
   parameter int DATA_W     = 32,
   parameter bit RESET_ZERO = 1'b1
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     we,
   input  logic [$clog2(NREGS)-1:0] waddr,
   input  logic [DATA_W-1:0]        wdata,
   input  logic [$clog2(NREGS)-1:0] raddr,
   output logic [DATA_W-1:0]        rdata
);
   localparam int RW = $clog2(NREGS);

   logic [DATA_W-1:0] view [NREGS];

   generate
      for (genvar r = 0; r < NREGS; r++) begin : g_reg
         logic [DATA_W-1:0] val_q;
         logic              sel;
         assign sel = we && (waddr == RW'(r));
         if (RESET_ZERO) begin : g_rst
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n)   val_q <= '0;
               else if (sel) val_q <= wdata;
            end
         end else begin : g_nrst
            always_ff @(posedge clk) begin
               if (sel) val_q <= wdata;
            end
         end
         assign view[r] = val_q;
      end
   endgenerate

   assign rdata = view[raddr];
endmodule

// File: rtl/icb_commit.sv
module icb_commit
   import icb_pkg::*;
#(
   parameter int DEPTH  = 16,
   parameter int DATA_W = 32,
   parameter int PC_W   = 32,
   parameter int XF_W   = 4,
   parameter int RW     = 3,
   parameter int CNT_W  = 16
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     h_valid,
   input  logic                     h_done,
   input  logic                     h_fence,
   input  logic                     h_wr,
   input  logic [RW-1:0]            h_dst,
   input  logic [DATA_W-1:0]        h_data,
   input  logic [XF_W-1:0]          h_flags,
   input  logic [PC_W-1:0]          h_pc,
   input  logic [$clog2(DEPTH)-1:0] h_tag,
   input  logic [XF_W-1:0]          flag_mask,
   input  logic                     step_en,
   input  logic                     sb_empty,
   output logic                     pop,
   output logic                     flush,
   output logic                     rf_we,
   output logic [RW-1:0]            rf_waddr,
   output logic [DATA_W-1:0]        rf_wdata,
   output logic                     retire_valid,
   output logic [$clog2(DEPTH)-1:0] retire_tag,
   output logic                     trap_valid,
   output logic                     trap_step,
   output logic [PC_W-1:0]          trap_pc,
   output logic [XF_W-1:0]          trap_flags,
   output logic [CNT_W-1:0]         retired_count
);
   localparam int TW = $clog2(DEPTH);

   logic            ready, fault, commit, stepped;
   logic [XF_W-1:0] live_flags;

   logic            rv_q, tv_q;
   logic [TW-1:0]   rtag_q;
   trap_kind_e      kind_q;
   logic [PC_W-1:0] tpc_q;
   logic [XF_W-1:0] tfl_q;
   logic [CNT_W-1:0] cnt_q;

   // the oldest slot alone decides; a fence also waits for the store buffer
   assign ready      = h_valid && h_done && (!h_fence || sb_empty);
   assign live_flags = h_flags & ~flag_mask;
   assign fault      = ready && (live_flags != '0);
   assign commit     = ready && !fault;
   assign stepped    = commit && step_en;

   assign pop      = commit;
   assign flush    = fault || stepped;
   assign rf_we    = commit && h_wr && !h_fence;
   assign rf_waddr = h_dst;
   assign rf_wdata = h_data;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rv_q   <= 1'b0;
         tv_q   <= 1'b0;
         rtag_q <= '0;
         kind_q <= TRAP_FAULT;
         tpc_q  <= '0;
         tfl_q  <= '0;
         cnt_q  <= '0;
      end else begin
         rv_q   <= commit;
         rtag_q <= h_tag;
         tv_q   <= flush;
         kind_q <= fault ? TRAP_FAULT : TRAP_STEP;
         tpc_q  <= h_pc;
         tfl_q  <= fault ? live_flags : '0;
         if (commit) cnt_q <= cnt_q + CNT_W'(1);
      end
   end

   assign retire_valid  = rv_q;
   assign retire_tag    = rtag_q;
   assign trap_valid    = tv_q;
   assign trap_step     = (kind_q == TRAP_STEP);
   assign trap_pc       = tpc_q;
   assign trap_flags    = tfl_q;
   assign retired_count = cnt_q;

   // R3
   head_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pop |-> (h_valid && h_done));

   // R5
   count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      retire_valid |-> (retired_count == $past(retired_count) + CNT_W'(1)));

   // R5
   count_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !retire_valid |-> $stable(retired_count));

   // R6
   fault_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (trap_valid && !trap_step) |-> !retire_valid);

   // R8
   step_after_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (trap_valid && trap_step) |-> retire_valid);

   // R9
   fence_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pop && h_fence) |-> sb_empty);
endmodule

// File: rtl/inorder_commit_buf.sv
module inorder_commit_buf #(
   parameter int DEPTH      = 16,
   parameter int DATA_W     = 32,
   parameter int PC_W       = 32,
   parameter int XF_W       = 4,
   parameter int NREGS      = 8,
   parameter int CNT_W      = 16,
   parameter bit RF_RST_ZERO = 1'b1
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     disp_valid,
   input  logic                     disp_fence,
   input  logic                     disp_wr,
   input  logic [$clog2(NREGS)-1:0] disp_dst,
   input  logic [PC_W-1:0]          disp_pc,
   output logic                     disp_ready,
   output logic [$clog2(DEPTH)-1:0] disp_tag,
   input  logic                     wb_valid,
   input  logic [$clog2(DEPTH)-1:0] wb_tag,
   input  logic [DATA_W-1:0]        wb_data,
   input  logic [XF_W-1:0]          wb_flags,
   input  logic [XF_W-1:0]          flag_mask,
   input  logic                     step_en,
   input  logic                     sb_empty,
   input  logic [$clog2(NREGS)-1:0] arf_addr,
   output logic [DATA_W-1:0]        arf_data,
   output logic                     retire_valid,
   output logic [$clog2(DEPTH)-1:0] retire_tag,
   output logic                     trap_valid,
   output logic                     trap_step,
   output logic [PC_W-1:0]          trap_pc,
   output logic [XF_W-1:0]          trap_flags,
   output logic [CNT_W-1:0]         retired_count,
   output logic [$clog2(DEPTH):0]   occupancy,
   output logic                     buf_full,
   output logic                     buf_empty
);
   localparam int TW = $clog2(DEPTH);
   localparam int RW = $clog2(NREGS);

   generate
      if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
         $error("DEPTH must be a power of two and at least 2");
      end
      if (NREGS < 2 || (NREGS & (NREGS - 1)) != 0) begin : g_bad_nregs
         $error("NREGS must be a power of two and at least 2");
      end
      if (XF_W < 1 || CNT_W < 1 || DATA_W < 1 || PC_W < 1) begin : g_bad_width
         $error("widths must be positive");
      end
   endgenerate

   logic              alloc, pop, flush;
   logic              h_valid, h_done, h_fence, h_wr;
   logic [RW-1:0]     h_dst;
   logic [DATA_W-1:0] h_data;
   logic [XF_W-1:0]   h_flags;
   logic [PC_W-1:0]   h_pc;
   logic [TW-1:0]     h_tag;
   logic              rf_we;
   logic [RW-1:0]     rf_waddr;
   logic [DATA_W-1:0] rf_wdata;

   assign disp_ready = !buf_full && !flush;
   assign alloc      = disp_valid && disp_ready;

   icb_slots #(
      .DEPTH(DEPTH), .DATA_W(DATA_W), .PC_W(PC_W), .XF_W(XF_W), .RW(RW)
   ) u_slots (
      .clk(clk), .rst_n(rst_n),
      .alloc(alloc), .a_fence(disp_fence), .a_wr(disp_wr),
      .a_dst(disp_dst), .a_pc(disp_pc),
      .wb_valid(wb_valid), .wb_tag(wb_tag), .wb_data(wb_data), .wb_flags(wb_flags),
      .pop(pop), .flush(flush),
      .h_valid(h_valid), .h_done(h_done), .h_fence(h_fence), .h_wr(h_wr),
      .h_dst(h_dst), .h_data(h_data), .h_flags(h_flags), .h_pc(h_pc),
      .h_tag(h_tag), .tail_tag(disp_tag),
      .count(occupancy), .full(buf_full), .empty(buf_empty)
   );

   icb_commit #(
      .DEPTH(DEPTH), .DATA_W(DATA_W), .PC_W(PC_W), .XF_W(XF_W),
      .RW(RW), .CNT_W(CNT_W)
   ) u_commit (
      .clk(clk), .rst_n(rst_n),
      .h_valid(h_valid), .h_done(h_done), .h_fence(h_fence), .h_wr(h_wr),
      .h_dst(h_dst), .h_data(h_data), .h_flags(h_flags), .h_pc(h_pc),
      .h_tag(h_tag),
      .flag_mask(flag_mask), .step_en(step_en), .sb_empty(sb_empty),
      .pop(pop), .flush(flush),
      .rf_we(rf_we), .rf_waddr(rf_waddr), .rf_wdata(rf_wdata),
      .retire_valid(retire_valid), .retire_tag(retire_tag),
      .trap_valid(trap_valid), .trap_step(trap_step),
      .trap_pc(trap_pc), .trap_flags(trap_flags),
      .retired_count(retired_count)
   );

   icb_arch_rf #(
      .NREGS(NREGS), .DATA_W(DATA_W), .RESET_ZERO(RF_RST_ZERO)
   ) u_rf (
      .clk(clk), .rst_n(rst_n),
      .we(rf_we), .waddr(rf_waddr), .wdata(rf_wdata),
      .raddr(arf_addr), .rdata(arf_data)
   );

   // R2
   rf_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !retire_valid |-> $stable(u_rf.view[arf_addr]) || $changed(arf_addr));
endmodule

// File: tb/inorder_commit_buf_test.sv
`timescale 1ns/1ps
module inorder_commit_buf_test;
   localparam int D = 16;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        disp_valid = 0, disp_fence = 0, disp_wr = 0;
   logic [2:0]  disp_dst = 0;
   logic [31:0] disp_pc = 0;
   logic        disp_ready;
   logic [3:0]  disp_tag;
   logic        wb_valid = 0;
   logic [3:0]  wb_tag = 0;
   logic [31:0] wb_data = 0;
   logic [3:0]  wb_flags = 0, flag_mask = 0;
   logic        step_en = 0, sb_empty = 1;
   logic [2:0]  arf_addr = 0;
   logic [31:0] arf_data;
   logic        retire_valid, trap_valid, trap_step, buf_full, buf_empty;
   logic [3:0]  retire_tag, trap_flags;
   logic [31:0] trap_pc;
   logic [15:0] retired_count;
   logic [4:0]  occupancy;

   always #4 clk = ~clk;

   inorder_commit_buf uut (
      .clk(clk), .rst_n(rst_n),
      .disp_valid(disp_valid), .disp_fence(disp_fence), .disp_wr(disp_wr),
      .disp_dst(disp_dst), .disp_pc(disp_pc), .disp_ready(disp_ready), .disp_tag(disp_tag),
      .wb_valid(wb_valid), .wb_tag(wb_tag), .wb_data(wb_data), .wb_flags(wb_flags),
      .flag_mask(flag_mask), .step_en(step_en), .sb_empty(sb_empty),
      .arf_addr(arf_addr), .arf_data(arf_data),
      .retire_valid(retire_valid), .retire_tag(retire_tag),
      .trap_valid(trap_valid), .trap_step(trap_step), .trap_pc(trap_pc),
      .trap_flags(trap_flags), .retired_count(retired_count),
      .occupancy(occupancy), .buf_full(buf_full), .buf_empty(buf_empty)
   );

   int checks = 0, errors = 0;
   bit finished = 0;

   // requirement-level model of the buffer
   bit          mv[D], md[D], mf[D], mw[D];
   logic [2:0]  mdst[D];
   logic [31:0] mdat[D], mpc[D];
   logic [3:0]  mx[D];
   int          mh = 0, mcnt = 0, mret = 0;
   logic [31:0] marf[8];
   logic [3:0]  k_msk = 0;
   bit          k_se = 0, k_sb = 1;
   logic [2:0]  k_ra = 0;
   logic [3:0]  last_tag = 0;

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   function automatic int tail_of();
      return (mh + mcnt) % D;
   endfunction

   task automatic step_cycle(input bit dv, input bit fn, input bit de,
                             input logic [2:0] dd, input logic [31:0] dpc,
                             input bit wv, input logic [3:0] wt,
                             input logic [31:0] wd, input logic [3:0] wx);
      bit rdy, flt, cmt, stp, fl, exp_rdy, alloc;
      bit e_rv, e_tv, e_ts;
      logic [3:0]  e_rtag, e_tfl, live;
      logic [31:0] e_tpc;
      int tl, h;
      disp_valid = dv; disp_fence = fn; disp_wr = de; disp_dst = dd; disp_pc = dpc;
      wb_valid = wv; wb_tag = wt; wb_data = wd; wb_flags = wx;
      flag_mask = k_msk; step_en = k_se; sb_empty = k_sb; arf_addr = k_ra;
      #1;
      h    = mh;
      tl   = tail_of();
      live = mx[h] & ~k_msk;
      rdy  = (mcnt > 0) && mv[h] && md[h] && (!mf[h] || k_sb);
      flt  = rdy && (live != 0);
      cmt  = rdy && !flt;
      stp  = cmt && k_se;
      fl   = flt || stp;
      exp_rdy = (mcnt < D) && !fl;
      chk(disp_ready == exp_rdy, "R1", "disp_ready", disp_ready, exp_rdy);
      if (exp_rdy) chk(disp_tag == tl[3:0], "R1", "disp_tag", disp_tag, tl);
      chk(arf_data == marf[k_ra], "R2 R4", "arf_data", arf_data, marf[k_ra]);
      chk(occupancy == mcnt[4:0], "R1 R7", "occupancy", occupancy, mcnt);
      chk(buf_empty == (mcnt == 0), "R1", "buf_empty", buf_empty, mcnt == 0);
      alloc = dv && exp_rdy;
      if (alloc) last_tag = tl[3:0];
      e_rv = cmt; e_rtag = h[3:0]; e_tv = fl; e_ts = stp; e_tpc = mpc[h];
      e_tfl = flt ? live : 4'h0;
      if (cmt && mw[h] && !mf[h]) marf[mdst[h]] = mdat[h];
      if (wv && mv[wt] && !fl) begin md[wt] = 1; mdat[wt] = wd; mx[wt] = wx; end
      if (cmt) begin mv[h] = 0; mh = (mh + 1) % D; mcnt--; mret++; end
      if (fl) begin
         for (int i = 0; i < D; i++) mv[i] = 0;
         mcnt = 0;
      end
      if (alloc) begin
         mv[tl] = 1; md[tl] = fn; mf[tl] = fn; mw[tl] = de; mdst[tl] = dd;
         mpc[tl] = dpc; mx[tl] = 0; mdat[tl] = 0; mcnt++;
      end
      @(negedge clk);
      chk(retire_valid == e_rv, "R3 R4", "retire_valid", retire_valid, e_rv);
      if (e_rv) chk(retire_tag == e_rtag, "R3", "retire_tag", retire_tag, e_rtag);
      chk(trap_valid == e_tv, "R6 R8", "trap_valid", trap_valid, e_tv);
      if (e_tv) begin
         chk(trap_step == e_ts, "R8", "trap_step", trap_step, e_ts);
         chk(trap_pc == e_tpc, "R6", "trap_pc", trap_pc, e_tpc);
         chk(trap_flags == e_tfl, "R6", "trap_flags", trap_flags, e_tfl);
      end
      chk(retired_count == mret[15:0], "R5", "retired_count", retired_count, mret);
   endtask

   task automatic do_disp(input bit fn, input bit de, input logic [2:0] dd,
                          input logic [31:0] pc);
      step_cycle(1, fn, de, dd, pc, 0, 0, 0, 0);
   endtask

   task automatic do_wb(input logic [3:0] t, input logic [31:0] d, input logic [3:0] x);
      step_cycle(0, 0, 0, 0, 0, 1, t, d, x);
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) step_cycle(0, 0, 0, 0, 0, 0, 0, 0, 0);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         errors++;
         $display("FAIL watchdog expired");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      logic [3:0] t_c, base;
      int r0;
      for (int i = 0; i < 8; i++) marf[i] = 0;
      for (int i = 0; i < D; i++) begin mv[i] = 0; md[i] = 0; mx[i] = 0; mf[i] = 0; end
      void'($urandom(32'd20240611));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      chk(buf_empty && !buf_full && occupancy == 0, "R1", "reset empty", occupancy, 0);
      chk(!retire_valid && !trap_valid && retired_count == 0, "R5", "reset outputs",
          retired_count, 0);

      // R3: younger finished entry waits behind unfinished head
      do_disp(0, 1, 3'd1, 32'h100);
      do_disp(0, 1, 3'd2, 32'h104);
      do_wb(4'd1, 32'hBB, 0);
      k_ra = 3'd2;
      idle(3);
      chk(occupancy == 2 && retired_count == 0, "R3", "blocked head", occupancy, 2);
      chk(arf_data == 0, "R2", "no early write", arf_data, 0);
      do_wb(4'd0, 32'hAA, 0);
      idle(3);
      chk(arf_data == 32'hBB, "R4", "committed value", arf_data, 32'hBB);

      // R9: fence holds until the store buffer drains
      k_sb = 0;
      do_disp(1, 0, 0, 32'h200);
      r0 = mret;
      idle(4);
      chk(occupancy == 1 && retired_count == r0[15:0], "R9", "fence held", occupancy, 1);
      k_sb = 1;
      idle(2);
      chk(retired_count == 16'(r0 + 1), "R9", "fence committed", retired_count, r0 + 1);

      // R6 R7: fault at head discards it and everything younger
      do_disp(0, 1, 3'd3, 32'h300);
      t_c = last_tag;
      do_disp(0, 1, 3'd4, 32'h304);
      do_wb(t_c + 4'd1, 32'h44, 0);
      do_wb(t_c, 32'h33, 4'b0100);
      k_ra = 3'd3;
      idle(1);
      chk(trap_valid && !trap_step && trap_pc == 32'h300, "R6", "fault trap", trap_pc, 32'h300);
      idle(1);
      chk(occupancy == 0 && arf_data == 0, "R7", "flushed", occupancy, 0);
      do_disp(0, 1, 3'd5, 32'h400);
      chk(last_tag == t_c, "R7", "tail to faulting tag", last_tag, t_c);

      // R6: fully masked flags commit normally
      k_msk = 4'b0001; k_ra = 3'd5;
      do_wb(last_tag, 32'h55, 4'b0001);
      idle(2);
      chk(arf_data == 32'h55 && !trap_valid, "R6", "masked flag", arf_data, 32'h55);
      k_msk = 0;

      // R8: fault beats step; step flushes younger work
      k_se = 1;
      do_disp(0, 1, 3'd6, 32'h500);
      t_c = last_tag;
      do_disp(0, 1, 3'd6, 32'h504);
      do_wb(t_c, 32'h66, 4'b1000);
      idle(1);
      chk(trap_valid && !trap_step, "R8", "fault priority", trap_step, 0);
      do_disp(0, 1, 3'd7, 32'h600);
      t_c = last_tag;
      do_disp(0, 1, 3'd7, 32'h604);
      do_wb(t_c, 32'h77, 0);
      k_ra = 3'd7;
      do_wb(t_c + 4'd1, 32'h78, 0);
      chk(trap_valid && trap_step && trap_pc == 32'h600, "R8", "step trap", trap_pc, 32'h600);
      idle(2);
      chk(occupancy == 0 && arf_data == 32'h77, "R8", "step flush", arf_data, 32'h77);
      k_se = 0;

      // R10: writeback to an empty slot is ignored
      t_c = 4'(tail_of());
      do_wb(t_c, 32'h99, 0);
      do_disp(0, 1, 3'd0, 32'h700);
      idle(4);
      chk(occupancy == 1, "R10", "stale writeback", occupancy, 1);
      do_wb(t_c, 32'h9A, 0);
      idle(2);

      // R1: fill every slot, then complete in reverse order
      base = 4'(mh);
      for (int i = 0; i < D; i++) do_disp(0, 1, 3'(i), 32'h800 + 32'(i * 4));
      do_disp(0, 1, 3'd0, 32'h900);
      chk(buf_full && occupancy == 16, "R1", "full", occupancy, 16);
      for (int i = D - 1; i >= 0; i--) do_wb(base + 4'(i), 32'h1000 + 32'(i), 0);
      idle(20);
      chk(buf_empty, "R3", "drained", occupancy, 0);

      // mixed random traffic
      for (int n = 0; n < 3000; n++) begin
         bit dv, fn, de, wv;
         logic [3:0] wt, wx;
         int st;
         dv = ($urandom % 4) != 0;
         fn = ($urandom % 10) == 0;
         de = 1'($urandom % 2);
         wv = ($urandom % 3) != 0;
         st = $urandom % D;
         wt = 4'(st);
         if (($urandom % 8) != 0) begin
            for (int k = 0; k < D; k++) begin
               if (mv[(st + k) % D] && !md[(st + k) % D]) begin
                  wt = 4'((st + k) % D);
                  break;
               end
            end
         end
         wx = (($urandom % 12) == 0) ? 4'($urandom % 16) : 4'h0;
         k_msk = (($urandom % 4) == 0) ? 4'b0011 : 4'b0000;
         k_se  = ($urandom % 20) == 0;
         k_sb  = ($urandom % 4) != 0;
         k_ra  = 3'($urandom % 8);
         step_cycle(dv, fn, de, 3'($urandom % 8), $urandom, wv, wt, $urandom, wx);
      end

      finished = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule